// File: doc/BRIEF.md
# Sleep-Aware Pad State Controller

This block owns the pad controls of a bank of general-purpose pins and of three static-memory strobe pins (write strobe, output strobe, chip-select 0). It decides, for every pin and in every phase, whether the pad drives, which value it drives, whether its input buffer is on and whether its pull-up is on. The phases are reset, normal running, a one-cycle sleep entry, sleep, and wake.

Software reaches the block through a small write port. Through that port it sets pin directions, run-time output data, per-pin sleep values for the general-purpose pins and the strobes, and a float-select bit for the strobes. It also clears a read-hold flag. After reset, and again after every sleep, that flag keeps input buffers off and returns zero as the input value. Only the reset turns pull-ups on. Clearing the hold is the one thing that turns them off, and sleep does not turn them back on.

A controller FSM has three named states. PS_RUN is the reset state. PS_ENTRY lasts one cycle. PS_SLEEP holds until wake. The transitions are T_REQ (PS_RUN to PS_ENTRY on `sleep_req_i`), T_ENTER (PS_ENTRY to PS_SLEEP, taken without a condition) and T_WAKE (PS_SLEEP to PS_RUN on `wake_i`). Every other case stays in the current state.

Top module: `pad_sleep_ctrl`

## Requirements
- R1: During and right after reset the FSM is in PS_RUN. All general-purpose pins are undriven (`pad_oe_o`=0), their input buffers are off and their pull-ups are on. The strobes are driven (`strobe_oe_o`=3'b111) and pass `mem_strobe_i` through. `sleep_active_o`=0.
- R2: Register map, written by `wr_en_i` with `wr_addr_i`:
  - 0: direction, where 1 means output.
  - 1: run-time output data.
  - 2: general-purpose sleep values.
  - 3: strobe sleep values, using `wr_data_i[2:0]`.
  - 4: float-select, using `wr_data_i[0]`.
  - 5: hold clear, using `wr_data_i[0]`=1.

  In PS_RUN the pads follow direction and run data from the cycle after the write.
- R3: In PS_RUN, a hold-clear write turns all input buffers on and all pull-ups off from the next cycle.
- R4: `sleep_req_i` in PS_RUN gives exactly one PS_ENTRY cycle and then PS_SLEEP. In PS_ENTRY the general-purpose pins keep their run values. The strobes are driven to 3'b111 if float-select is 0, or undriven if it is 1. `sleep_active_o` is 1 exactly in PS_SLEEP.
- R5: In PS_SLEEP each general-purpose pin follows the direction captured in PS_ENTRY. It drives the sleep value captured in PS_ENTRY (`pad_out_o` shows that value for every pin), and an input pin does not drive.
- R6: In PS_SLEEP, if the captured float-select is 1, the strobes are undriven. If it is 0, they drive the captured strobe sleep values.
- R7: Leaving PS_ENTRY sets the hold again, so input buffers are off in sleep. Pull-ups keep the state they had before sleep.
- R8: Register writes made in PS_ENTRY or PS_SLEEP do not change any pad output during sleep. They take effect after wake.
- R9: `wake_i` in PS_SLEEP returns the pads to run direction, run data and strobe pass-through on the next cycle. The hold stays set until software clears it.
- R10: `rd_in_o` is 0 while the hold is set and equals `pad_in_i` otherwise.
- R11: The following are ignored and leave every output unchanged:
  - a hold-clear write outside PS_RUN;
  - `wake_i` outside PS_SLEEP;
  - `sleep_req_i` outside PS_RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register select |
| wr_data_i | input | N_GPIO | Write data |
| sleep_req_i | input | 1 | Request to enter sleep |
| wake_i | input | 1 | Wake event |
| mem_strobe_i | input | 3 | Run-time strobe values from the memory controller |
| pad_in_i | input | N_GPIO | Raw pad input values |
| pad_oe_o | output | N_GPIO | Pad output enable |
| pad_out_o | output | N_GPIO | Pad output value |
| pad_ie_o | output | N_GPIO | Input buffer enable |
| pad_pu_o | output | N_GPIO | Pull-up enable |
| strobe_oe_o | output | 3 | Strobe output enable |
| strobe_out_o | output | 3 | Strobe output value |
| rd_in_o | output | N_GPIO | Input data as seen by software |
| sleep_active_o | output | 1 | High while in PS_SLEEP |

## Verification
The hardest case to reach is a register write or hold clear that lands in the single PS_ENTRY cycle or in the middle of sleep. To check it, the bench must show that sleep pads use the values captured at entry, and that the new values show up only after wake. Directed sequences schedule writes in exactly those cycles. A fixed-seed random phase then mixes sleep requests, wakes, writes and hold clears in every state. It compares each cycle against a bench model of the FSM and the registers.

// File: rtl/pad_sleep_pkg.sv
package pad_sleep_pkg;
    localparam int NSTB = 3;
    localparam int AW   = 3;

    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_ENTRY = 2'd1,
        PS_SLEEP = 2'd2
    } pad_st_e;

    localparam logic [AW-1:0] A_DIR   = 3'd0;
    localparam logic [AW-1:0] A_RUN   = 3'd1;
    localparam logic [AW-1:0] A_SLP   = 3'd2;
    localparam logic [AW-1:0] A_SSTB  = 3'd3;
    localparam logic [AW-1:0] A_CFG   = 3'd4;
    localparam logic [AW-1:0] A_HCLR  = 3'd5;
endpackage

// File: rtl/pad_sleep_fsm.sv
module pad_sleep_fsm
    import pad_sleep_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sleep_req_i,
    input  logic    wake_i,
    output pad_st_e st_o,
    output logic    in_entry_o,
    output logic    in_sleep_o
);
    pad_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PS_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PS_RUN:   if (sleep_req_i) st_d = PS_ENTRY;   // T_REQ
            PS_ENTRY: st_d = PS_SLEEP;                     // T_ENTER
            PS_SLEEP: if (wake_i) st_d = PS_RUN;           // T_WAKE
            default:  st_d = PS_RUN;
        endcase
    end

    always_comb begin
        in_entry_o = 1'b0;
        in_sleep_o = 1'b0;
        unique case (st_q)
            PS_RUN:   ;
            PS_ENTRY: in_entry_o = 1'b1;
            PS_SLEEP: in_sleep_o = 1'b1;
            default:  ;
        endcase
    end

    assign st_o = st_q;
endmodule

// File: rtl/pad_sleep_regs.sv
module pad_sleep_regs
    import pad_sleep_pkg::*;
#(
    parameter int N_GPIO = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [N_GPIO-1:0] wr_data_i,
    input  pad_st_e           st_i,
    output logic [N_GPIO-1:0] dir_o,
    output logic [N_GPIO-1:0] run_o,
    output logic [N_GPIO-1:0] slp_o,
    output logic [NSTB-1:0]   sstb_o,
    output logic              fs_o,
    output logic              hold_o,
    output logic              pu_o
);
    logic hclr;
    assign hclr = wr_en_i && (wr_addr_i == A_HCLR) && wr_data_i[0] && (st_i == PS_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_o  <= '0;
            run_o  <= '0;
            slp_o  <= '0;
            sstb_o <= '1;
            fs_o   <= 1'b0;
        end else if (wr_en_i) begin
            unique case (wr_addr_i)
                A_DIR:   dir_o  <= wr_data_i;
                A_RUN:   run_o  <= wr_data_i;
                A_SLP:   slp_o  <= wr_data_i;
                A_SSTB:  sstb_o <= wr_data_i[NSTB-1:0];
                A_CFG:   fs_o   <= wr_data_i[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_o <= 1'b1;
            pu_o   <= 1'b1;
        end else if (st_i == PS_ENTRY) begin
            hold_o <= 1'b1;
        end else if (hclr) begin
            hold_o <= 1'b0;
            pu_o   <= 1'b0;
        end
    end
endmodule

// File: rtl/pad_sleep_snap.sv
module pad_sleep_snap
    import pad_sleep_pkg::*;
#(
    parameter int N_GPIO = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [N_GPIO-1:0] dir_i,
    input  logic [N_GPIO-1:0] slp_i,
    input  logic [NSTB-1:0]   sstb_i,
    input  logic              fs_i,
    output logic [N_GPIO-1:0] dir_o,
    output logic [N_GPIO-1:0] slp_o,
    output logic [NSTB-1:0]   sstb_o,
    output logic              fs_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_o  <= '0;
            slp_o  <= '0;
            sstb_o <= '1;
            fs_o   <= 1'b0;
        end else if (cap_i) begin
            dir_o  <= dir_i;
            slp_o  <= slp_i;
            sstb_o <= sstb_i;
            fs_o   <= fs_i;
        end
    end
endmodule

// File: rtl/pad_sleep_mux.sv
module pad_sleep_mux
    import pad_sleep_pkg::*;
#(
    parameter int N_GPIO = 8
) (
    input  pad_st_e           st_i,
    input  logic [N_GPIO-1:0] dir_i,
    input  logic [N_GPIO-1:0] run_i,
    input  logic              fs_i,
    input  logic [N_GPIO-1:0] snap_dir_i,
    input  logic [N_GPIO-1:0] snap_slp_i,
    input  logic [NSTB-1:0]   snap_sstb_i,
    input  logic              snap_fs_i,
    input  logic [NSTB-1:0]   mem_strobe_i,
    output logic [N_GPIO-1:0] oe_o,
    output logic [N_GPIO-1:0] out_o,
    output logic [NSTB-1:0]   stb_oe_o,
    output logic [NSTB-1:0]   stb_out_o
);
    always_comb begin
        oe_o      = dir_i;
        out_o     = run_i;
        stb_oe_o  = '1;
        stb_out_o = mem_strobe_i;
        unique case (st_i)
            PS_RUN: ;
            PS_ENTRY: begin
                stb_oe_o  = fs_i ? '0 : '1;
                stb_out_o = '1;
            end
            PS_SLEEP: begin
                oe_o      = snap_dir_i;
                out_o     = snap_slp_i;
                stb_oe_o  = snap_fs_i ? '0 : '1;
                stb_out_o = snap_sstb_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pad_sleep_ctrl.sv
module pad_sleep_ctrl
    import pad_sleep_pkg::*;
#(
    parameter int N_GPIO = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_addr_i,
    input  logic [N_GPIO-1:0] wr_data_i,
    input  logic              sleep_req_i,
    input  logic              wake_i,
    input  logic [2:0]        mem_strobe_i,
    input  logic [N_GPIO-1:0] pad_in_i,
    output logic [N_GPIO-1:0] pad_oe_o,
    output logic [N_GPIO-1:0] pad_out_o,
    output logic [N_GPIO-1:0] pad_ie_o,
    output logic [N_GPIO-1:0] pad_pu_o,
    output logic [2:0]        strobe_oe_o,
    output logic [2:0]        strobe_out_o,
    output logic [N_GPIO-1:0] rd_in_o,
    output logic              sleep_active_o
);
    pad_st_e           st;
    logic              in_entry, in_sleep;
    logic [N_GPIO-1:0] dir, run, slp, snap_dir, snap_slp;
    logic [NSTB-1:0]   sstb, snap_sstb;
    logic              fs, snap_fs, hold, pu;

    pad_sleep_fsm u_fsm (
        .clk, .rst_n,
        .sleep_req_i, .wake_i,
        .st_o(st), .in_entry_o(in_entry), .in_sleep_o(in_sleep)
    );

    pad_sleep_regs #(.N_GPIO(N_GPIO)) u_regs (
        .clk, .rst_n,
        .wr_en_i, .wr_addr_i, .wr_data_i,
        .st_i(st),
        .dir_o(dir), .run_o(run), .slp_o(slp), .sstb_o(sstb),
        .fs_o(fs), .hold_o(hold), .pu_o(pu)
    );

    pad_sleep_snap #(.N_GPIO(N_GPIO)) u_snap (
        .clk, .rst_n,
        .cap_i(in_entry),
        .dir_i(dir), .slp_i(slp), .sstb_i(sstb), .fs_i(fs),
        .dir_o(snap_dir), .slp_o(snap_slp), .sstb_o(snap_sstb), .fs_o(snap_fs)
    );

    pad_sleep_mux #(.N_GPIO(N_GPIO)) u_mux (
        .st_i(st),
        .dir_i(dir), .run_i(run), .fs_i(fs),
        .snap_dir_i(snap_dir), .snap_slp_i(snap_slp),
        .snap_sstb_i(snap_sstb), .snap_fs_i(snap_fs),
        .mem_strobe_i,
        .oe_o(pad_oe_o), .out_o(pad_out_o),
        .stb_oe_o(strobe_oe_o), .stb_out_o(strobe_out_o)
    );

    assign pad_ie_o       = {N_GPIO{~hold}};
    assign pad_pu_o       = {N_GPIO{pu}};
    assign rd_in_o        = hold ? '0 : pad_in_i;
    assign sleep_active_o = in_sleep;
endmodule

// File: rtl/pad_sleep_chk.sv
module pad_sleep_chk
    import pad_sleep_pkg::*;
#(
    parameter int N_GPIO = 8
) (
    input logic              clk,
    input logic              rst_n,
    input pad_st_e           st,
    input logic              wake_i,
    input logic              snap_fs,
    input logic [N_GPIO-1:0] snap_dir,
    input logic [N_GPIO-1:0] pad_oe_o,
    input logic [N_GPIO-1:0] pad_out_o,
    input logic [N_GPIO-1:0] pad_ie_o,
    input logic [N_GPIO-1:0] pad_pu_o,
    input logic [2:0]        strobe_oe_o,
    input logic [2:0]        strobe_out_o,
    input logic [N_GPIO-1:0] rd_in_o,
    input logic              sleep_active_o
);
    AST_ENTRY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        st == PS_ENTRY |=> sleep_active_o); // R4
    AST_ENTRY_STROBE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_ENTRY && strobe_oe_o != '0) |-> strobe_out_o == 3'b111); // R4
    AST_SLEEP_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_active_o |-> (pad_oe_o & ~snap_dir) == '0); // R5
    AST_SLEEP_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_active_o && snap_fs) |-> strobe_oe_o == '0); // R6
    AST_SLEEP_IE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_active_o |-> pad_ie_o == '0); // R7
    AST_PU_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(pad_pu_o[0])); // R7
    AST_SLEEP_PADS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_active_o && $past(sleep_active_o)) |-> ($stable(pad_oe_o) && $stable(pad_out_o))); // R8
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_active_o && wake_i) |=> !sleep_active_o); // R9
    AST_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_ie_o[0] |-> rd_in_o == '0); // R10
endmodule

bind pad_sleep_ctrl pad_sleep_chk #(.N_GPIO(N_GPIO)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .wake_i(wake_i),
    .snap_fs(snap_fs), .snap_dir(snap_dir),
    .pad_oe_o(pad_oe_o), .pad_out_o(pad_out_o), .pad_ie_o(pad_ie_o),
    .pad_pu_o(pad_pu_o), .strobe_oe_o(strobe_oe_o), .strobe_out_o(strobe_out_o),
    .rd_in_o(rd_in_o), .sleep_active_o(sleep_active_o)
);

// File: tb/tb_pad_sleep_ctrl.sv
module tb_pad_sleep_ctrl;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [N-1:0] wr_data = '0;
    logic         sleep_req = 1'b0;
    logic         wake = 1'b0;
    logic [2:0]   mem_stb = 3'b111;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_oe, pad_out, pad_ie, pad_pu, rd_in;
    logic [2:0]   stb_oe, stb_out;
    logic         sleep_act;

    always #4 clk = ~clk;

    pad_sleep_ctrl #(.N_GPIO(N)) dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .sleep_req_i(sleep_req), .wake_i(wake),
        .mem_strobe_i(mem_stb), .pad_in_i(pad_in),
        .pad_oe_o(pad_oe), .pad_out_o(pad_out), .pad_ie_o(pad_ie), .pad_pu_o(pad_pu),
        .strobe_oe_o(stb_oe), .strobe_out_o(stb_out),
        .rd_in_o(rd_in), .sleep_active_o(sleep_act)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    // bench model: 0 run, 1 entry, 2 sleep
    int           m_st;
    logic [N-1:0] m_dir, m_run, m_slp, s_dir, s_slp;
    logic [2:0]   m_sstb, s_sstb;
    logic         m_fs, s_fs, m_hold, m_pu;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_st = 0; m_dir = '0; m_run = '0; m_slp = '0; m_sstb = 3'b111; m_fs = 0;
        m_hold = 1; m_pu = 1; s_dir = '0; s_slp = '0; s_sstb = 3'b111; s_fs = 0;
    endtask

    function automatic logic [N-1:0] exp_oe();
        return (m_st == 2) ? s_dir : m_dir;
    endfunction
    function automatic logic [N-1:0] exp_out();
        return (m_st == 2) ? s_slp : m_run;
    endfunction
    function automatic logic [2:0] exp_soe();
        if (m_st == 1) return m_fs ? 3'b000 : 3'b111;
        if (m_st == 2) return s_fs ? 3'b000 : 3'b111;
        return 3'b111;
    endfunction
    function automatic logic [2:0] exp_sout();
        if (m_st == 1) return 3'b111;
        if (m_st == 2) return s_sstb;
        return mem_stb;
    endfunction

    task automatic check_all(input string tag);
        chk(tag, "pad_oe", 64'(pad_oe), 64'(exp_oe()));
        chk(tag, "pad_out", 64'(pad_out), 64'(exp_out()));
        chk(tag, "pad_ie", 64'(pad_ie), 64'({N{~m_hold}}));
        chk(tag, "pad_pu", 64'(pad_pu), 64'({N{m_pu}}));
        chk(tag, "strobe_oe", 64'(stb_oe), 64'(exp_soe()));
        chk(tag, "strobe_out", 64'(stb_out), 64'(exp_sout()));
        chk(tag, "rd_in", 64'(rd_in), 64'(m_hold ? '0 : pad_in));
        chk(tag, "sleep_active", 64'(sleep_act), 64'(m_st == 2));
    endtask

    // advance model across one rising edge using the inputs driven now
    task automatic model_step();
        int           nst = m_st;
        logic [N-1:0] ndir = m_dir, nrun = m_run, nslp = m_slp;
        logic [2:0]   nsstb = m_sstb;
        logic         nfs = m_fs, nhold = m_hold, npu = m_pu;
        if (wr_en) begin
            case (wr_addr)
                3'd0: ndir = wr_data;
                3'd1: nrun = wr_data;
                3'd2: nslp = wr_data;
                3'd3: nsstb = wr_data[2:0];
                3'd4: nfs = wr_data[0];
                3'd5: if (wr_data[0] && m_st == 0) begin nhold = 0; npu = 0; end
                default: ;
            endcase
        end
        if (m_st == 1) begin
            s_dir = m_dir; s_slp = m_slp; s_sstb = m_sstb; s_fs = m_fs;
            nhold = 1;
        end
        if (m_st == 0 && sleep_req) nst = 1;
        else if (m_st == 1) nst = 2;
        else if (m_st == 2 && wake) nst = 0;
        m_st = nst; m_dir = ndir; m_run = nrun; m_slp = nslp; m_sstb = nsstb;
        m_fs = nfs; m_hold = nhold; m_pu = npu;
    endtask

    // one cycle: inputs already set at the falling edge; check, then step
    task automatic cycle(input string tag);
        #1;
        check_all(tag);
        model_step();
        @(negedge clk);
        wr_en = 0; sleep_req = 0; wake = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d, input string tag);
        wr_en = 1; wr_addr = a; wr_data = d;
        cycle(tag);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        model_reset();
        mem_stb = 3'b111;
        pad_in = 8'hA5;
        repeat (3) @(negedge clk);
        check_all("R1");           // reset state while held
        rst_n = 1;
        @(negedge clk);
        cycle("R1");
        cycle("R10");               // input reads zero with hold set

        // R2 register writes in run
        wr(3'd0, 8'hF0, "R2");
        wr(3'd1, 8'h5A, "R2");
        mem_stb = 3'b010; cycle("R2");
        wr(3'd2, 8'h3C, "R2");
        wr(3'd3, 8'h005, "R2");
        // R3 hold clear in run
        wr(3'd5, 8'h01, "R3");
        pad_in = 8'h96; cycle("R10");

        // R4/R5/R6 sleep with float-select 0, write in entry cycle (R8)
        sleep_req = 1; cycle("R4");
        wr(3'd2, 8'hFF, "R8");      // entry cycle write
        wr(3'd0, 8'h0F, "R8");      // sleep: write direction
        wr(3'd5, 8'h01, "R11");     // hold clear ignored in sleep
        sleep_req = 1; cycle("R11");
        cycle("R5");
        cycle("R6");
        cycle("R7");
        wake = 1; cycle("R9");
        cycle("R9");                // run with new direction, hold still set
        wake = 1; cycle("R11");     // wake outside sleep ignored
        wr(3'd5, 8'h01, "R3");
        cycle("R10");

        // float-select 1
        wr(3'd4, 8'h01, "R6");
        sleep_req = 1; cycle("R4");
        cycle("R6");
        cycle("R6");
        wake = 1; cycle("R9");
        wr(3'd4, 8'h00, "R6");

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            wr_en   = ($urandom_range(0, 2) == 0);
            wr_addr = 3'($urandom_range(0, 5));
            wr_data = N'($urandom);
            mem_stb = 3'($urandom);
            pad_in  = N'($urandom);
            sleep_req = ($urandom_range(0, 9) == 0);
            wake      = ($urandom_range(0, 5) == 0);
            if (wr_addr == 3'd5 && $urandom_range(0, 7) != 0) wr_en = 0;
            cycle("R8");
        end

        // mid-run reset returns to reset state
        rst_n = 0;
        #1;
        model_reset();
        @(negedge clk);
        check_all("R1");
        rst_n = 1;
        @(negedge clk);
        cycle("R1");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule